// File: doc/BRIEF.md
# Shared memory window address translator

This block turns a 20-bit host bus address into an address on a local buffer memory. The host can see the buffer only through a window: a range of host addresses that starts at a configured base and spans a configured size. When a host address falls inside that window and host access to the buffer is enabled, the block subtracts the window base from the address. It then adds a page offset chosen by a small control field. The result is the buffer address.

The page field lets a buffer that is larger than the window be reached one page at a time. Each page is 8 KB. With the page field at zero, the mapping is the plain base-relative offset. The page field is 3 bits wide by default. It can be widened through a parameter, for example to 5 bits, and the buffer address widens with it.

Both outputs are registered. They reflect the inputs sampled on the previous rising clock edge. The block does not handle bus cycle timing or the memory itself.

Top module: `win_xlate`

## Requirements
- R1: While reset is asserted, `sel` is 0 and `buf_addr` is 0.
- R2: One clock after the inputs are sampled, `sel` is 1 if and only if all three of these hold: `mem_en` is 1, `host_addr >= win_base`, and `host_addr < win_base + win_size`.
- R3: When `mem_en` is 0, the next cycle shows `sel` = 0 and `buf_addr` = 0, whatever the address is.
- R4: When the address hits, the next cycle shows `buf_addr` = ((`host_addr` - `win_base`) + `page_sel`*2^13) mod 2^16. The page field drives buffer address bits 15..13 in the default configuration.
- R5: With `page_sel` = 0, `buf_addr` equals `host_addr - win_base` for every hit.
- R6: If the page addition carries past bit 15, the carry is discarded, so the buffer address wraps within the 64 KB buffer.
- R7: The window end is exclusive. `win_base + win_size` is evaluated with one extra bit, so a window that ends exactly at the top of the 20-bit space still hits on its last address.
- R8: A `win_size` of 0 never hits.
- R9: Whenever `sel` is 0, `buf_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 20 | Host bus address |
| win_base | input | 20 | First host address of the window |
| win_size | input | 20 | Window length in bytes |
| page_sel | input | PAGE_W (3) | Page offset field, in 8 KB pages |
| mem_en | input | 1 | Host buffer access enable |
| buf_addr | output | PAGE_LSB+PAGE_W (16) | Registered buffer address |
| sel | output | 1 | Registered window hit |

## Verification
Two functions can meet in a single cycle. One is the window hit decision at the exclusive upper edge. The other is the page addition that wraps past the top of the buffer. The bench provokes this by sweeping addresses across both window edges while stepping through every page value. The high pages combined with offsets near the window end force the carry to be dropped in the same cycle as the edge comparison. Each result is judged against a hit flag and a masked sum that the bench computes arithmetically. A second collision is `mem_en` falling in the same cycle as an in-window address. That case must give `sel` = 0 and a zero address.

// File: rtl/win_xlate.sv
module win_xlate #(
  parameter int HA_W     = 20,
  parameter int PAGE_W   = 3,
  parameter int PAGE_LSB = 13,
  localparam int BA_W    = PAGE_LSB + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HA_W-1:0]   host_addr,
  input  logic [HA_W-1:0]   win_base,
  input  logic [HA_W-1:0]   win_size,
  input  logic [PAGE_W-1:0] page_sel,
  input  logic              mem_en,
  output logic [BA_W-1:0]   buf_addr,
  output logic              sel
);

  logic [HA_W:0]   win_end;
  logic            above_base, below_end, hit;
  logic [HA_W-1:0] rel;
  logic [BA_W-1:0] page_off, sum;

  assign win_end    = {1'b0, win_base} + {1'b0, win_size};
  assign above_base = host_addr >= win_base;
  assign below_end  = {1'b0, host_addr} < win_end;
  assign hit        = mem_en & above_base & below_end;

  assign rel      = host_addr - win_base;
  assign page_off = {page_sel, {PAGE_LSB{1'b0}}};

  generate
    if (HA_W >= BA_W) begin : g_trunc
      assign sum = rel[BA_W-1:0] + page_off;
    end else begin : g_ext
      assign sum = {{(BA_W-HA_W){1'b0}}, rel} + page_off;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= 1'b0;
      buf_addr <= '0;
    end else begin
      sel      <= hit;
      buf_addr <= hit ? sum : '0;
    end
  end

endmodule

// File: rtl/win_xlate_chk.sv
module win_xlate_chk #(
  parameter int HA_W     = 20,
  parameter int PAGE_W   = 3,
  parameter int PAGE_LSB = 13,
  localparam int BA_W    = PAGE_LSB + PAGE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HA_W-1:0]   host_addr,
  input logic [HA_W-1:0]   win_base,
  input logic [HA_W-1:0]   win_size,
  input logic [PAGE_W-1:0] page_sel,
  input logic              mem_en,
  input logic [BA_W-1:0]   buf_addr,
  input logic              sel
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      a_r1_reset_quiet: assert (!sel && buf_addr == '0);
    end
  end

  a_r3_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !mem_en) |=> !sel);

  a_r2_below_base_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && host_addr < win_base) |=> !sel);

  a_r8_zero_size_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && win_size == '0) |=> !sel);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> buf_addr == '0);

  a_r5_direct_map: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && page_sel == '0 && mem_en && host_addr >= win_base &&
     ({1'b0, host_addr} < {1'b0, win_base} + {1'b0, win_size}))
    |=> (sel && buf_addr == $past(host_addr[BA_W-1:0] - win_base[BA_W-1:0])));

endmodule

bind win_xlate win_xlate_chk #(.HA_W(HA_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)) chk_i (.*);

// File: tb/win_xlate_tb_top.sv
`timescale 1ns/1ps
module win_xlate_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] host_addr = '0, win_base = '0, win_size = '0;
  logic [2:0]  page_sel = '0;
  logic        mem_en = 1'b0;
  logic [15:0] buf_addr;
  logic        sel;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  win_xlate dut_i (.clk(clk), .rst_n(rst_n), .host_addr(host_addr), .win_base(win_base),
    .win_size(win_size), .page_sel(page_sel), .mem_en(mem_en), .buf_addr(buf_addr), .sel(sel));

  task automatic check(input string req, input logic [15:0] ea, input logic es);
    n_run++;
    if (buf_addr !== ea || sel !== es) begin
      n_fail++;
      $display("FAIL %s: sel=%0b buf_addr=%h expected sel=%0b buf_addr=%h", req, sel, buf_addr, es, ea);
    end
  endtask

  task automatic apply(input string req, input logic [19:0] a, input logic [19:0] b,
                       input logic [19:0] s, input logic [2:0] p, input logic en);
    logic hit;
    logic [19:0] rel;
    logic [15:0] exp_a;
    @(negedge clk);
    host_addr = a; win_base = b; win_size = s; page_sel = p; mem_en = en;
    hit = en && (a >= b) && ({1'b0, a} < {1'b0, b} + {1'b0, s});
    rel = a - b;
    exp_a = hit ? 16'(rel + (20'(p) << 13)) : 16'h0;
    @(negedge clk);
    check(req, exp_a, hit);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 16'h0, 1'b0);
    rst_n = 1'b1;

    for (int p = 0; p < 8; p++)
      for (int d = -3; d < 20'h2000 + 4; d += 511)
        apply(p == 0 ? "R5" : "R4", 20'(32'hC0000 + d), 20'hC0000, 20'h2000, 3'(p), 1'b1);

    for (int p = 0; p < 8; p++)
      for (int d = -2; d <= 2; d++)
        apply("R2", 20'(32'hC2000 + d), 20'hC0000, 20'h2000, 3'(p), 1'b1);

    for (int p = 5; p < 8; p++)
      for (int d = 1; d <= 3; d++)
        apply("R6", 20'(32'hD0000 - d), 20'hC0000, 20'h10000, 3'(p), 1'b1);

    for (int d = 1; d <= 3; d++)
      apply("R7", 20'(32'h100000 - d), 20'hFE000, 20'h2000, 3'd1, 1'b1);
    apply("R7", 20'h00000, 20'hFE000, 20'h2000, 3'd1, 1'b1);

    apply("R8", 20'hC0000, 20'hC0000, 20'h0, 3'd2, 1'b1);
    apply("R8", 20'hC0001, 20'hC0000, 20'h0, 3'd0, 1'b1);

    apply("R3", 20'hC0010, 20'hC0000, 20'h2000, 3'd3, 1'b0);
    apply("R4", 20'hC0010, 20'hC0000, 20'h2000, 3'd3, 1'b1);
    apply("R3", 20'hC0020, 20'hC0000, 20'h2000, 3'd3, 1'b0);
    apply("R9", 20'h12345, 20'hC0000, 20'h2000, 3'd7, 1'b1);
    n_run++;
    if (sel === 1'b0 && buf_addr !== 16'h0) begin
      n_fail++;
      $display("FAIL R9: buf_addr=%h expected 0", buf_addr);
    end

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 16'h0, 1'b0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule